// File: doc/BRIEF.md
# Nibble Rotate Execution Unit

This unit carries out the decimal digit rotate between an 8-bit accumulator and one byte of memory. A start pulse supplies the direction, the current accumulator and the current carry flag. The unit then reads the memory byte through a request/acknowledge read port. It moves three nibbles as one group: the accumulator low nibble and both nibbles of the memory byte. It writes the new memory byte back through a request/acknowledge write port. Last, it presents the new accumulator and the updated condition flags together with a one-cycle completion pulse.

The host core supplies the memory address and the rest of its flag register. The unit does not handle either of them. The accumulator's upper nibble passes through untouched. The flags describe the new accumulator and not the byte written to memory.

Top module: `nibble_rotate_unit`

## Requirements
- R1: With `dir_right`=0 (left rotate), the new accumulator low nibble is the old memory high nibble. The written memory byte has the old memory low nibble in bits 7:4 and the old accumulator low nibble in bits 3:0.
- R2: With `dir_right`=1 (right rotate), the new accumulator low nibble is the old memory low nibble. The written memory byte has the old accumulator low nibble in bits 7:4 and the old memory high nibble in bits 3:0.
- R3: Bits 7:4 of `acc_out` equal bits 7:4 of the accumulator sampled at start.
- R4: On completion, `flag_n` and `flag_h` are 0.
- R5: On completion, `flag_p` is 1 when `acc_out` has an even number of set bits and 0 otherwise.
- R6: On completion, `flag_z` is 1 exactly when `acc_out` is zero, and `flag_s` equals bit 7 of `acc_out`.
- R7: On completion, `flag_c` equals `carry_in` sampled with the start pulse.
- R8: `rd_req` rises in the cycle after start and stays high until the cycle of `rd_ack`. `wr_req` is high from the next cycle until the cycle of `wr_ack`, and `wr_data` stays steady during that time. `done` is high for exactly the cycle after `wr_ack`. `acc_out` and the flags change only in that same cycle.
- R9: The unit ignores `start` while an operation is in progress (`busy`=1). The operands and direction captured at the accepted start are used, even if the inputs change afterwards.
- R10: After reset, `busy`, `rd_req`, `wr_req` and `done` are 0, `acc_out` is 0 and all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| dir_right | input | 1 | 0 = left digit rotate, 1 = right digit rotate |
| acc_in | input | 8 | Accumulator value, sampled with start |
| carry_in | input | 1 | Current carry flag, sampled with start |
| busy | output | 1 | Operation in progress |
| rd_req | output | 1 | Memory read request |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 8 | Memory byte read |
| wr_req | output | 1 | Memory write request |
| wr_data | output | 8 | Memory byte to write |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | New accumulator |
| flag_s | output | 1 | Sign of new accumulator |
| flag_z | output | 1 | New accumulator is zero |
| flag_h | output | 1 | Half carry (cleared) |
| flag_p | output | 1 | Even parity of new accumulator |
| flag_n | output | 1 | Subtract flag (cleared) |
| flag_c | output | 1 | Carry, passed through unchanged |

## Verification
The hardest case to reach from the ports is a second start, with different operands, that arrives while the unit is still waiting on a memory acknowledge. Only the delay that memory inserts makes that wait exist. The bench's memory responder holds each acknowledge for a chosen number of cycles, from none to several. During such a hold it pulses `start` with a new accumulator and direction. It then confirms that the result reflects only the first operands and that no second read follows. A zero-delay acknowledge, which arrives in the first request cycle, covers the opposite extreme of the handshake.

// File: rtl/nibble_rotate_unit.sv
module nibble_rotate_unit #(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 dir_right,
  input  logic [2*NIB_W-1:0]   acc_in,
  input  logic                 carry_in,
  output logic                 busy,
  output logic                 rd_req,
  input  logic                 rd_ack,
  input  logic [2*NIB_W-1:0]   rd_data,
  output logic                 wr_req,
  output logic [2*NIB_W-1:0]   wr_data,
  input  logic                 wr_ack,
  output logic                 done,
  output logic [2*NIB_W-1:0]   acc_out,
  output logic                 flag_s,
  output logic                 flag_z,
  output logic                 flag_h,
  output logic                 flag_p,
  output logic                 flag_n,
  output logic                 flag_c
);
  localparam int W = 2 * NIB_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} st_t;
  st_t st;

  logic         dir_q, carry_q;
  logic [W-1:0] acc_q, acc_new_q, mem_new_q;
  logic [W-1:0] acc_calc, mem_calc;

  wire [NIB_W-1:0] a_lo = acc_q[NIB_W-1:0];
  wire [NIB_W-1:0] a_hi = acc_q[W-1:NIB_W];
  wire [NIB_W-1:0] m_lo = rd_data[NIB_W-1:0];
  wire [NIB_W-1:0] m_hi = rd_data[W-1:NIB_W];

  assign acc_calc = dir_q ? {a_hi, m_lo} : {a_hi, m_hi};
  assign mem_calc = dir_q ? {a_lo, m_hi} : {m_lo, a_lo};

  assign busy    = (st != ST_IDLE);
  assign rd_req  = (st == ST_READ);
  assign wr_req  = (st == ST_WRITE);
  assign wr_data = mem_new_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dir_q     <= 1'b0;
      carry_q   <= 1'b0;
      acc_q     <= '0;
      acc_new_q <= '0;
      mem_new_q <= '0;
      done      <= 1'b0;
      acc_out   <= '0;
      flag_s    <= 1'b0;
      flag_z    <= 1'b0;
      flag_h    <= 1'b0;
      flag_p    <= 1'b0;
      flag_n    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          dir_q   <= dir_right;
          carry_q <= carry_in;
          acc_q   <= acc_in;
          st      <= ST_READ;
        end
        ST_READ: if (rd_ack) begin
          acc_new_q <= acc_calc;
          mem_new_q <= mem_calc;
          st        <= ST_WRITE;
        end
        ST_WRITE: if (wr_ack) begin
          acc_out <= acc_new_q;
          flag_s  <= acc_new_q[W-1];
          flag_z  <= (acc_new_q == '0);
          flag_p  <= ~^acc_new_q;
          flag_h  <= 1'b0;
          flag_n  <= 1'b0;
          flag_c  <= carry_q;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_rotate_unit_chk.sv
module nibble_rotate_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_req,
  input logic         rd_ack,
  input logic         wr_req,
  input logic         wr_ack,
  input logic [W-1:0] wr_data,
  input logic         done,
  input logic [W-1:0] acc_out,
  input logic         flag_z,
  input logic         flag_c
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);                                  // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_data));              // R8
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> wr_req && !rd_req);                        // R8
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> done);                                     // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R8
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));                                           // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && wr_ack) |=> $stable(acc_out) && $stable(flag_c));   // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_z == (acc_out == '0));                            // R6
endmodule

bind nibble_rotate_unit nibble_rotate_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data), .done(done),
  .acc_out(acc_out), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/nibble_rotate_unit_tb.sv
module nibble_rotate_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, dir_right = 0, carry_in = 0, rd_ack = 0, wr_ack = 0;
  logic [7:0] acc_in = 0, rd_data = 0;
  logic busy, rd_req, wr_req, done;
  logic [7:0] wr_data, acc_out;
  logic flag_s, flag_z, flag_h, flag_p, flag_n, flag_c;

  int checks = 0, errors = 0;
  bit finished = 0;

  nibble_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_right(dir_right),
    .acc_in(acc_in), .carry_in(carry_in), .busy(busy), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_data(wr_data),
    .wr_ack(wr_ack), .done(done), .acc_out(acc_out), .flag_s(flag_s),
    .flag_z(flag_z), .flag_h(flag_h), .flag_p(flag_p), .flag_n(flag_n),
    .flag_c(flag_c)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int even_par(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // One full operation; compares the outputs at every negedge.
  task automatic run_op(int acc, int mem, bit right, bit cy, int rlat, int wlat, bit poke);
    int exp_acc, exp_mem;
    if (right) begin
      exp_acc = (acc & 'hF0) | (mem & 'h0F);
      exp_mem = ((acc & 'h0F) << 4) | (mem >> 4);
    end else begin
      exp_acc = (acc & 'hF0) | (mem >> 4);
      exp_mem = ((mem & 'h0F) << 4) | (acc & 'h0F);
    end
    start = 1; acc_in = acc[7:0]; dir_right = right; carry_in = cy;
    @(negedge clk);
    start = 0;
    acc_in = ~acc[7:0]; dir_right = ~right; carry_in = ~cy;  // R9 captured at start
    for (int i = 0; i < rlat; i++) begin
      chk("R8 rd_req held", rd_req, 1); chk("R8 no wr_req", wr_req, 0); chk("R8 no done", done, 0);
      if (poke && i == 0) begin start = 1; acc_in = 8'h5A; end  // R9 start while busy
      @(negedge clk);
      start = 0;
    end
    chk("R8 rd_req", rd_req, 1);
    rd_ack = 1; rd_data = mem[7:0];
    @(negedge clk);
    rd_ack = 0; rd_data = 8'hEE;
    for (int i = 0; i < wlat; i++) begin
      chk("R8 wr_req held", wr_req, 1); chk("R8 rd_req off", rd_req, 0);
      chk(right ? "R2 wr_data" : "R1 wr_data", wr_data, exp_mem);
      if (poke && i == 0) start = 1;  // R9 start while busy
      @(negedge clk);
      start = 0;
    end
    chk("R8 wr_req", wr_req, 1);
    chk(right ? "R2 wr_data" : "R1 wr_data", wr_data, exp_mem);
    wr_ack = 1;
    @(negedge clk);
    wr_ack = 0;
    chk("R8 done", done, 1);
    chk(right ? "R2 acc_out" : "R1 acc_out", acc_out, exp_acc);
    chk("R3 acc high nibble", acc_out[7:4], (acc >> 4) & 'hF);
    chk("R4 flag_n", flag_n, 0); chk("R4 flag_h", flag_h, 0);
    chk("R5 flag_p", flag_p, even_par(exp_acc));
    chk("R6 flag_z", flag_z, exp_acc == 0);
    chk("R6 flag_s", flag_s, (exp_acc >> 7) & 1);
    chk("R7 flag_c", flag_c, cy);
    @(negedge clk);
    chk("R8 done pulse", done, 0);
    chk("R9 idle after op", busy, 0);
    chk("R9 no second read", rd_req, 0);
    chk("R8 acc stable", acc_out, exp_acc);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 busy", busy, 0); chk("R10 rd_req", rd_req, 0); chk("R10 wr_req", wr_req, 0);
    chk("R10 done", done, 0); chk("R10 acc_out", acc_out, 0);
    chk("R10 flags", {flag_s, flag_z, flag_h, flag_p, flag_n, flag_c}, 0);
    rst_n = 1;
    @(negedge clk);
    rd_ack = 1; wr_ack = 1;                 // R8 acks ignored when not requested
    @(negedge clk);
    rd_ack = 0; wr_ack = 0;
    chk("R8 stray ack", busy, 0); chk("R8 stray ack done", done, 0);
    run_op('h12, 'h34, 0, 1, 0, 0, 0);
    run_op('h12, 'h34, 1, 0, 1, 2, 0);
    run_op('h0A, 'h0B, 0, 0, 3, 1, 0);      // zero acc on left
    run_op('hF0, 'h50, 1, 1, 0, 3, 0);      // acc F0: sign set
    run_op('h00, 'h00, 1, 0, 2, 0, 0);      // all zero
    run_op('h87, 'hC3, 0, 1, 4, 4, 1);      // start while busy
    run_op('h3C, 'h9E, 1, 0, 2, 2, 1);
    for (int k = 0; k < 20; k++)
      run_op((k * 37 + 5) & 'hFF, (k * 91 + 17) & 'hFF, k[0], k[1], k % 3, (k + 1) % 3, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule